// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address stream for a four-beat burst on a synchronous memory port. A load strobe captures a full base address from outside, and that address is presented as the first beat. Every later clock edge on which the active-low advance input is asserted moves to the next beat. Only the low beat-select bits change; the upper bits keep their loaded value for the whole burst.

Two orders are offered. With the order input low, the low bits count upward from the loaded offset and wrap modulo the burst length. With it high, beat k presents the loaded offset XOR k. While advance is deasserted the current address is held, so a burst can be suspended for any number of cycles. After the last beat a further advance wraps back to the loaded base. A load at any beat discards the running burst and starts a new one. Load and advance are plain level controls sampled at the rising clock edge. No valid/ready handshake is used because there is no back-pressure: the output is a registered state that is always valid. The order input is combinational into the output and must be tied high at integration when interleaved order is wanted by default.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset the address output is all zeros.
- R2: On the edge after the one where load_i is high, addr_o equals the sampled base_i exactly, in either order.
- R3: While load_i is low, the bits of addr_o above the low BEAT_W bits do not change.
- R4: With order_i = 0 (linear), each edge with load_i low and adv_n_i low makes the low two bits one greater than before, modulo 4 (for example 01, 10, 11, 00).
- R5: With order_i = 1 (interleaved), beat k of a burst shows the loaded low two bits XOR k (for example 10, 11, 00, 01).
- R6: An edge with load_i low and adv_n_i high leaves addr_o unchanged while order_i is stable.
- R7: The fifth beat, reached by four advances after a load, equals the loaded base again in both orders.
- R8: A load in the middle of a burst restarts from the new base; load_i takes priority over adv_n_i on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture base_i and start a new burst |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| base_i | input | ADDR_W | External start address |
| order_i | input | 1 | 0 = linear, 1 = interleaved |
| addr_o | output | ADDR_W | Current burst address |

## Verification
A wrong beat counter or captured base shows up in addr_o one clock after the edge that caused it, because the output is formed directly from those two registers. A counter that skips or stalls breaks the linear step or the interleaved XOR pattern on the next beat and keeps the error until the next load. A corrupted upper part shows up at once as a change in the high bits during a burst. The scoreboard predicts every cycle's address from its own model of base and beat index. This covers all four starting offsets in both orders, suspension, wrap and reload.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (load_i) base_q <= base_i;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_n_i,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  // load wins over advance (R8); counter wraps naturally (R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_q <= '0;
    else if (load_i)   beat_q <= '0;
    else if (!adv_n_i) beat_q <= beat_q + ONE;
  end
endmodule

// File: rtl/burst_addr_form.sv
module burst_addr_form
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base_q,
  input  logic [BEAT_W-1:0] beat_q,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] low_lin, low_ilv, low_sel;
  burst_order_e      ord;

  assign ord     = burst_order_e'(order_i);
  assign low_lin = base_q[BEAT_W-1:0] + beat_q;
  assign low_ilv = base_q[BEAT_W-1:0] ^ beat_q;

  always_comb begin
    case (ord)
      ORD_LINEAR: low_sel = low_lin;
      default:    low_sel = low_ilv;
    endcase
  end

  generate
    if (UP_W > 0) begin : g_upper
      assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_sel};
    end else begin : g_flat
      assign addr_o = low_sel;
    end
  endgenerate
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [BEAT_W-1:0] STEP = BEAT_W'(1);

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .base_i(base_i), .base_q(base_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i), .beat_q(beat_q)
  );

  burst_addr_form #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_form (
    .base_q(base_q), .beat_q(beat_q), .order_i(order_i), .addr_o(addr_o)
  );

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(base_i));

  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  a_r6_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> (!$stable(order_i) || $stable(addr_o)));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && !order_i) |=>
      (order_i || addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + STEP));
endmodule

// File: tb/tb_burst_seq_gen.sv
module tb_burst_seq_gen;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_n_i = 1'b1;
  logic [AW-1:0] base_i = '0;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic [AW-1:0] m_base = '0;
  int            m_k = 0;

  burst_seq_gen #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
    .base_i(base_i), .order_i(order_i), .addr_o(addr_o)
  );

  always #4 clk = ~clk; // 125 MHz

  function automatic logic [AW-1:0] ref_addr(logic [AW-1:0] b, int k, logic ord);
    logic [1:0] lo;
    lo = ord ? (b[1:0] ^ 2'(k)) : 2'((int'(b[1:0]) + k) % 4);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: sets inputs 2ns after an edge, predicts output after next edge
  task automatic cyc(logic ld, logic adv_n, logic [AW-1:0] b, logic ord, string tag);
    exp_t e;
    @(posedge clk); #2;
    load_i = ld; adv_n_i = adv_n; base_i = b; order_i = ord;
    if (ld) begin m_base = b; m_k = 0; end
    else if (!adv_n) m_k = m_k + 1;
    e.addr = ref_addr(m_base, m_k, ord);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: 1ns after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check("R3 upper bits", {addr_o[AW-1:2], 2'b00}, {e.addr[AW-1:2], 2'b00});
      check(e.tag, addr_o, e.addr);
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] b;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", addr_o, '0);
    @(negedge clk); rst_n = 1'b1;

    // every offset, both orders: load, four advances (last wraps)
    for (int ord = 0; ord < 2; ord++) begin
      for (int off = 0; off < 4; off++) begin
        b = {18'(20'h5A3C1 + off * 7 + ord * 13), 2'(off)};
        cyc(1'b1, 1'b1, b, 1'(ord), "R2 first beat");
        for (int k = 1; k <= 3; k++)
          cyc(1'b0, 1'b0, b, 1'(ord), ord ? "R5 interleaved beat" : "R4 linear beat");
        cyc(1'b0, 1'b0, b, 1'(ord), "R7 wrap to base");
        cyc(1'b0, 1'b0, b, 1'(ord), ord ? "R5 second lap" : "R4 second lap");
      end
    end

    // suspension mid-burst
    b = 20'hABCD2;
    cyc(1'b1, 1'b1, b, 1'b0, "R2 first beat");
    cyc(1'b0, 1'b0, b, 1'b0, "R4 linear beat");
    for (int h = 0; h < 3; h++) cyc(1'b0, 1'b1, b, 1'b0, "R6 suspended hold");
    cyc(1'b0, 1'b0, b, 1'b0, "R6 resume after hold");
    b = 20'h13571;
    cyc(1'b1, 1'b1, b, 1'b1, "R2 first beat");
    cyc(1'b0, 1'b0, b, 1'b1, "R5 interleaved beat");
    cyc(1'b0, 1'b1, b, 1'b1, "R6 suspended hold");
    cyc(1'b0, 1'b0, b, 1'b1, "R6 resume after hold");

    // reload mid-burst, with advance asserted on the load edge
    cyc(1'b0, 1'b0, b, 1'b1, "R5 interleaved beat");
    b = 20'hFEDC3;
    cyc(1'b1, 1'b0, b, 1'b1, "R8 reload restarts");
    cyc(1'b0, 1'b0, b, 1'b1, "R8 beat after reload");
    b = 20'h00011;
    cyc(1'b1, 1'b0, b, 1'b0, "R8 reload restarts");
    cyc(1'b0, 1'b0, b, 1'b0, "R8 beat after reload");
    cyc(1'b0, 1'b1, b, 1'b0, "R6 suspended hold");

    repeat (3) @(posedge clk);
    #3;
    if (sb.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard drain: got %0d left expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule